// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Write Protection

This block is a watchdog that software must service on a regular schedule. Once enabled, a single counter measures an interrupt window whose length is a power of two of the counting clock. When that window runs out, the block latches an expiry flag, and it can raise an interrupt. The counter then begins a second, shorter window. If software does not service the watchdog before this second window ends, the block drives a system reset pulse of fixed length.

Control writes are guarded so that a stray store does not reconfigure or service the timer. A key word written to the lock register opens exactly one later write to the configuration register or to the service register. Servicing also needs its own key word. The counting clock is either every bus clock cycle or a qualified external tick. A narrow-counter build caps the interrupt window at the longest setting a 16-bit counter can hold.

Top module: `dual_stage_watchdog`

## Requirements
- R1: After reset, the interrupt and reset outputs are low, the configuration reads 0, the status reads 0 and the block is locked.
- R2: While locked, a write to the configuration register (offset 0x10) or to the service register (offset 0x14) has no effect.
- R3: Writing the full word 0x0000_5AA5 to the lock register (offset 0x18) opens exactly one following write to offset 0x10 or 0x14, and the block then relocks. Writing any other value to the lock register leaves the block locked.
- R4: With the enable bit (bit 0) and the interrupt-enable bit (bit 2) set, the interrupt output rises exactly 2^n counting clocks after the configuration write. Here n comes from the 4-bit code in bits 7:4 through the list 6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31 for codes 0 to 15.
- R5: Status bit 0 (offset 0x1C) is the expiry flag. The status register needs no key. Writing 1 to bit 0 clears the flag, and writing 0 leaves it unchanged. The interrupt output is the flag gated by bit 2.
- R6: After the interrupt window expires, a second window of 2^(7+c) counting clocks starts, where c is the 3-bit code in bits 10:8. If bit 3 is set and no service occurs, the reset output goes high at the end of this window for exactly PULSE_CYCLES (default 4) cycles.
- R7: With bit 3 clear, the reset output never goes high.
- R8: An unlocked write of the full word 0x0000_CAFE to offset 0x14 zeroes the counter and returns the block to the interrupt window. Any other unlocked value there still uses up the key and does nothing else.
- R9: Clearing bit 0 stops counting and zeroes the counter, and the expiry flag is not set while the block is disabled.
- R10: With bit 1 set, the counter advances every bus clock. With bit 1 clear, it advances only on cycles in which `extTick` is high.
- R11: With COUNTER_BITS below 32, interrupt codes above 7 behave as code 7 (2^15 counts).
- R12: Offset 0x00 reads ID_VALUE. Offset 0x10 reads back the 11 configuration bits, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, combinational from paddr |
| extTick | input | 1 | Count qualifier used when bit 1 is clear |
| wdtIrq | output | 1 | Expiry interrupt (level) |
| wdtRst | output | 1 | System reset pulse |

## Verification
The bench measures the exact cycle counts from enable to interrupt and from interrupt to reset, for directed and random codes. An off-by-one in the terminal compare, or a wrong entry in the exponent list, therefore appears as a wrong cycle number and not as a missed event. It also attacks the lock. It tries writes with the wrong key, a second write after one unlock, and a wrong service word that must still use up the key. A lock that stays open would let the later plain service write restart the count and move the interrupt. The bench services the timer in the middle of the reset window to show that servicing cancels the reset. It checks that clearing the flag with a 0 does nothing. It shows that the narrow build clamps code 15 to 2^15, while the full build is still counting at that point.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  localparam logic [7:0] OFF_ID      = 8'h00;
  localparam logic [7:0] OFF_CFG     = 8'h10;
  localparam logic [7:0] OFF_SERVICE = 8'h14;
  localparam logic [7:0] OFF_LOCK    = 8'h18;
  localparam logic [7:0] OFF_STATUS  = 8'h1C;

  localparam logic [31:0] UNLOCK_KEY  = 32'h0000_5AA5;
  localparam logic [31:0] SERVICE_KEY = 32'h0000_CAFE;

  // Field order is fixed: bit 0 enable up to bits 10:8 reset-window code.
  typedef struct packed {
    logic [2:0] rstCode;
    logic [3:0] intCode;
    logic       rstEn;
    logic       intEn;
    logic       clkSel;
    logic       enable;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic {STAGE_INT = 1'b0, STAGE_RST = 1'b1} stage_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic clear;
    logic advance;
    logic rstStage;
  } dpStrobe_t;

  // Interrupt-window exponent: two steps of 2, six steps of 1, eight steps of 2.
  function automatic logic [4:0] intExponent(input logic [3:0] code);
    if (code < 4'd2)      return 5'd6 + {code, 1'b0};
    else if (code < 4'd8) return {1'b0, code} + 5'd8;
    else                  return {code, 1'b1};
  endfunction

endpackage

// File: rtl/dsw_lock.sv
module dsw_lock (
  input  logic pclk,
  input  logic presetn,
  input  logic lockWrite,
  input  logic keyMatch,
  input  logic protWrite,
  output logic unlocked
);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      unlocked <= 1'b0;
    end else if (lockWrite) begin
      unlocked <= keyMatch;
    end else if (protWrite) begin
      unlocked <= 1'b0;
    end
  end

endmodule

// File: rtl/dsw_datapath.sv
module dsw_datapath
  import dsw_pkg::*;
#(
  parameter int COUNTER_BITS = 32
) (
  input  logic       pclk,
  input  logic       presetn,
  input  dpStrobe_t  strobe,
  input  logic [3:0] intCode,
  input  logic [2:0] rstCode,
  output logic       terminal
);

  localparam bit NARROW = COUNTER_BITS < 32;

  logic [3:0]              effCode;
  logic [4:0]              intN;
  logic [4:0]              rstN;
  logic [4:0]              selN;
  logic [COUNTER_BITS-1:0] mask;
  logic [COUNTER_BITS-1:0] count;

  generate
    if (NARROW) begin : gClamp
      assign effCode = (intCode > 4'd7) ? 4'd7 : intCode;
    end else begin : gFull
      assign effCode = intCode;
    end
  endgenerate

  always_comb begin
    intN     = intExponent(effCode);
    rstN     = 5'd7 + {2'b00, rstCode};
    selN     = strobe.rstStage ? rstN : intN;
    mask     = COUNTER_BITS'((64'd1 << selN) - 64'd1);
    terminal = strobe.advance && (count == mask);
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      count <= '0;
    end else if (strobe.clear) begin
      count <= '0;
    end else if (strobe.advance) begin
      count <= terminal ? '0 : count + 1'b1;
    end
  end

endmodule

// File: rtl/dsw_ctrl.sv
module dsw_ctrl
  import dsw_pkg::*;
#(
  parameter int          ADDR_W       = 5,
  parameter int          DATA_W       = 32,
  parameter int          PULSE_CYCLES = 4,
  parameter logic [31:0] ID_VALUE     = 32'h0D06_0200
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              unlocked,
  output logic              lockWrite,
  output logic              keyMatch,
  output logic              protWrite,
  input  logic              tick,
  input  logic              terminal,
  output cfg_t              cfgQ,
  output logic              flagQ,
  output dpStrobe_t         strobe,
  output logic              rstActive
);

  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic          wrAccess;
  logic          hitId;
  logic          hitCfg;
  logic          hitService;
  logic          hitLock;
  logic          hitStatus;
  logic          cfgLoad;
  logic          serviceHit;
  logic          statusClr;
  stage_e        stage;
  logic [PW-1:0] pulseCnt;

  always_comb begin
    wrAccess   = psel && penable && pwrite;
    hitId      = paddr == ADDR_W'(OFF_ID);
    hitCfg     = paddr == ADDR_W'(OFF_CFG);
    hitService = paddr == ADDR_W'(OFF_SERVICE);
    hitLock    = paddr == ADDR_W'(OFF_LOCK);
    hitStatus  = paddr == ADDR_W'(OFF_STATUS);
    lockWrite  = wrAccess && hitLock;
    keyMatch   = 32'(pwdata) == UNLOCK_KEY;
    protWrite  = wrAccess && (hitCfg || hitService);
    cfgLoad    = wrAccess && hitCfg && unlocked;
    serviceHit = wrAccess && hitService && unlocked && (32'(pwdata) == SERVICE_KEY);
    statusClr  = wrAccess && hitStatus && pwdata[0];
  end

  always_comb begin
    strobe.clear    = !cfgQ.enable || serviceHit;
    strobe.advance  = cfgQ.enable && tick && !serviceHit;
    strobe.rstStage = stage == STAGE_RST;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      cfgQ <= '0;
    end else if (cfgLoad) begin
      cfgQ <= cfg_t'(pwdata[CFG_W-1:0]);
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      stage <= STAGE_INT;
    end else if (strobe.clear) begin
      stage <= STAGE_INT;
    end else if (terminal) begin
      stage <= (stage == STAGE_INT) ? STAGE_RST : STAGE_INT;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      flagQ <= 1'b0;
    end else if (terminal && stage == STAGE_INT) begin
      flagQ <= 1'b1;
    end else if (statusClr) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      pulseCnt <= '0;
    end else if (terminal && stage == STAGE_RST && cfgQ.rstEn) begin
      pulseCnt <= PW'(PULSE_CYCLES);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign rstActive = pulseCnt != '0;

  always_comb begin
    prdata = '0;
    if (hitId)          prdata = DATA_W'(ID_VALUE);
    else if (hitCfg)    prdata = DATA_W'(cfgQ);
    else if (hitStatus) prdata = DATA_W'(flagQ);
  end

endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog
  import dsw_pkg::*;
#(
  parameter int          ADDR_W       = 5,
  parameter int          DATA_W       = 32,
  parameter int          COUNTER_BITS = 32,
  parameter int          PULSE_CYCLES = 4,
  parameter logic [31:0] ID_VALUE     = 32'h0D06_0200
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              extTick,
  output logic              wdtIrq,
  output logic              wdtRst
);

  logic      unlocked;
  logic      lockWrite;
  logic      keyMatch;
  logic      protWrite;
  logic      tick;
  logic      terminal;
  logic      flagQ;
  cfg_t      cfgQ;
  dpStrobe_t strobe;

  assign tick   = cfgQ.clkSel || extTick;
  assign wdtIrq = flagQ && cfgQ.intEn;

  dsw_lock uLock (
    .pclk      (pclk),
    .presetn   (presetn),
    .lockWrite (lockWrite),
    .keyMatch  (keyMatch),
    .protWrite (protWrite),
    .unlocked  (unlocked)
  );

  dsw_ctrl #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .PULSE_CYCLES (PULSE_CYCLES),
    .ID_VALUE     (ID_VALUE)
  ) uCtrl (
    .pclk      (pclk),
    .presetn   (presetn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .unlocked  (unlocked),
    .lockWrite (lockWrite),
    .keyMatch  (keyMatch),
    .protWrite (protWrite),
    .tick      (tick),
    .terminal  (terminal),
    .cfgQ      (cfgQ),
    .flagQ     (flagQ),
    .strobe    (strobe),
    .rstActive (wdtRst)
  );

  dsw_datapath #(
    .COUNTER_BITS (COUNTER_BITS)
  ) uDp (
    .pclk     (pclk),
    .presetn  (presetn),
    .strobe   (strobe),
    .intCode  (cfgQ.intCode),
    .rstCode  (cfgQ.rstCode),
    .terminal (terminal)
  );

endmodule

// File: rtl/dsw_checker.sv
module dsw_checker
  import dsw_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              unlocked,
  input logic [CFG_W-1:0]  cfgBits,
  input logic              flag,
  input logic              inRst,
  input logic              wdtRst
);

  logic wrCfg;
  logic wrProt;
  assign wrCfg  = psel && penable && pwrite && paddr == ADDR_W'(OFF_CFG);
  assign wrProt = wrCfg || (psel && penable && pwrite && paddr == ADDR_W'(OFF_SERVICE));

  // R2: a locked configuration write leaves the register untouched
  p_locked_cfg_hold_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (wrCfg && !unlocked) |=> $stable(cfgBits));

  // R3: any protected write leaves the block locked afterwards
  p_key_consumed_r3: assert property (@(posedge pclk) disable iff (!presetn)
    wrProt |=> !unlocked);

  // R4: the flag rises only as the interrupt window hands over to the reset window
  p_flag_at_handover_r4: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(flag) |-> (inRst && !$past(inRst)));

  // R6: the reset pulse starts as the reset window ends and lasts more than one cycle
  p_rst_from_window_r6: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(wdtRst) |-> ($past(inRst) && !inRst));

  p_rst_pulse_len_r6: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(wdtRst) |=> wdtRst);

  // R7: no reset pulse unless the reset enable was set
  p_rst_needs_enable_r7: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(wdtRst) |-> $past(cfgBits[3]));

  // R9: a disabled block never sets the flag
  p_idle_no_flag_r9: assert property (@(posedge pclk) disable iff (!presetn)
    !cfgBits[0] |=> !$rose(flag));

endmodule

bind dual_stage_watchdog dsw_checker #(.ADDR_W(ADDR_W)) uChk (
  .pclk     (pclk),
  .presetn  (presetn),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .unlocked (unlocked),
  .cfgBits  (cfgQ),
  .flag     (flagQ),
  .inRst    (strobe.rstStage),
  .wdtRst   (wdtRst)
);

// File: tb/tb_dual_stage_watchdog.sv
`timescale 1ns/1ps
module tb_dual_stage_watchdog;

  localparam logic [31:0] IDV = 32'h0D06_0200;
  localparam int PULSE = 4;
  localparam logic [4:0] A_ID = 5'h00, A_CFG = 5'h10, A_SVC = 5'h14,
                         A_LOCK = 5'h18, A_STAT = 5'h1C;

  logic clk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata16;
  logic extTick = 1'b0;
  logic wdtIrq, wdtRst, irq16, rst16;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_stage_watchdog #(.COUNTER_BITS(32), .PULSE_CYCLES(PULSE), .ID_VALUE(IDV)) dut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .extTick(extTick),
    .wdtIrq(wdtIrq), .wdtRst(wdtRst));

  dual_stage_watchdog #(.COUNTER_BITS(16), .PULSE_CYCLES(PULSE), .ID_VALUE(IDV)) dut16 (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata16), .extTick(extTick),
    .wdtIrq(irq16), .wdtRst(rst16));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL R4 watchdog expired: cycles=%0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int expN(input int code);
    case (code)
      0: return 6;   1: return 8;   2: return 10;  3: return 11;
      4: return 12;  5: return 13;  6: return 14;  7: return 15;
      8: return 17;  9: return 19;  10: return 21; 11: return 23;
      12: return 25; 13: return 27; 14: return 29; default: return 31;
    endcase
  endfunction

  function automatic logic [31:0] cfgWord(input int ic, input int rc, input bit rEn,
                                          input bit iEn, input bit cSel, input bit en);
    return (32'(rc) << 8) | (32'(ic) << 4) | (32'(rEn) << 3) | (32'(iEn) << 2)
         | (32'(cSel) << 1) | 32'(en);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    d = prdata;
    psel = 1'b0;
  endtask

  task automatic unlock();
    busWrite(A_LOCK, 32'h0000_5AA5);
  endtask

  task automatic stopAll();
    unlock();
    busWrite(A_CFG, 32'h0);
    busWrite(A_STAT, 32'h1);
  endtask

  task automatic waitIrq(input int maxC, output int at);
    at = -1;
    for (int i = 0; i < maxC; i++) begin
      @(negedge clk);
      if (wdtIrq) begin
        at = cyc;
        break;
      end
    end
  endtask

  // Enables with given codes and measures interrupt and reset timing.
  task automatic runTimed(input int ic, input int rc, input bit rEn, input bit doStop);
    int start, firstIrq, firstRst, rstLen, win;
    if (doStop) stopAll();
    unlock();
    busWrite(A_CFG, cfgWord(ic, rc, rEn, 1'b1, 1'b1, 1'b1));
    start = cyc; firstIrq = -1; firstRst = -1; rstLen = 0;
    win = (1 << expN(ic)) + (1 << (7 + rc)) + 12;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (wdtIrq && firstIrq < 0) firstIrq = cyc;
      if (wdtRst) begin
        if (firstRst < 0) firstRst = cyc;
        rstLen++;
      end
    end
    chk("R4", $sformatf("irq delay code %0d", ic), firstIrq - start, 1 << expN(ic));
    if (rEn) begin
      chk("R6", $sformatf("reset delay code %0d", rc), firstRst - firstIrq, 1 << (7 + rc));
      chk("R6", "reset pulse length", rstLen, PULSE);
    end else begin
      chk("R7", "reset cycles with reset disabled", rstLen, 0);
    end
  endtask

  initial begin
    logic [31:0] rd;
    int at, r, s, rc;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    presetn = 1'b1;
    @(negedge clk);

    // R1 / R12 reset state
    chk("R1", "irq after reset", wdtIrq, 0);
    chk("R1", "reset out after reset", wdtRst, 0);
    busRead(A_STAT, rd); chk("R1", "status after reset", rd, 0);
    busRead(A_CFG, rd);  chk("R1", "cfg after reset", rd, 0);
    busRead(A_ID, rd);   chk("R12", "id value", rd, IDV);

    // R2 locked writes, R3 wrong key and one-shot key
    busWrite(A_CFG, 32'h00C);
    busRead(A_CFG, rd); chk("R2", "cfg after locked write", rd, 0);
    busWrite(A_LOCK, 32'h0000_1234);
    busWrite(A_CFG, 32'h00C);
    busRead(A_CFG, rd); chk("R3", "cfg after wrong key", rd, 0);
    unlock();
    busWrite(A_CFG, 32'h00C);
    busRead(A_CFG, rd); chk("R3", "cfg after keyed write", rd, 32'h00C);
    busWrite(A_CFG, 32'h7F0);
    busRead(A_CFG, rd); chk("R3", "cfg after second unkeyed write", rd, 32'h00C);
    unlock();
    busWrite(A_CFG, 32'hFFFF_F7FE);
    busRead(A_CFG, rd); chk("R12", "cfg readback width", rd, 32'h7FE);
    stopAll();

    // R4 / R6 / R7 directed timing
    runTimed(0, 0, 1'b1, 1'b1);
    runTimed(2, 1, 1'b1, 1'b1);
    runTimed(0, 0, 1'b0, 1'b1);

    // R5 clear-by-one, flag still set from the run above
    busRead(A_STAT, rd); chk("R5", "flag set after expiry", rd, 1);
    busWrite(A_STAT, 32'h0);
    busRead(A_STAT, rd); chk("R5", "write 0 keeps flag", rd, 1);
    busWrite(A_STAT, 32'h1);
    busRead(A_STAT, rd); chk("R5", "write 1 clears flag", rd, 0);
    chk("R5", "irq after clear", wdtIrq, 0);

    // R4 / R6 / R7 random timing
    for (int k = 0; k < 6; k++) begin
      runTimed($urandom_range(0, 3), $urandom_range(0, 2), 1'($urandom_range(0, 1)), 1'b1);
    end

    // R8 service restarts the interrupt window
    stopAll(); unlock();
    busWrite(A_CFG, cfgWord(0, 0, 1'b1, 1'b1, 1'b1, 1'b1));
    repeat (40) @(negedge clk);
    unlock(); busWrite(A_SVC, 32'h0000_CAFE); r = cyc;
    waitIrq(300, at);
    chk("R8", "irq delay after service", at - r, 64);
    // service inside the reset window cancels the reset
    unlock(); busWrite(A_SVC, 32'h0000_CAFE); r = cyc; rc = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (wdtRst) rc++;
    end
    chk("R8", "reset cycles after service", rc, 0);
    // wrong service word uses up the key
    stopAll(); unlock();
    busWrite(A_CFG, cfgWord(0, 0, 1'b1, 1'b1, 1'b1, 1'b1)); s = cyc;
    repeat (10) @(negedge clk);
    unlock(); busWrite(A_SVC, 32'h0000_1234);
    busWrite(A_SVC, 32'h0000_CAFE);
    waitIrq(300, at);
    chk("R8", "irq delay after bad service", at - s, 64);

    // R9 stop by writing zero
    stopAll(); unlock();
    busWrite(A_CFG, cfgWord(0, 0, 1'b1, 1'b1, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    unlock(); busWrite(A_CFG, 32'h0);
    repeat (200) @(negedge clk);
    chk("R9", "irq after stop", wdtIrq, 0);
    busRead(A_STAT, rd); chk("R9", "status after stop", rd, 0);

    // R10 external tick qualifier
    stopAll(); unlock();
    busWrite(A_CFG, cfgWord(0, 0, 1'b0, 1'b1, 1'b0, 1'b1));
    repeat (150) @(negedge clk);
    chk("R10", "irq with no ticks", wdtIrq, 0);
    extTick = 1'b1; r = cyc;
    waitIrq(300, at);
    chk("R10", "irq delay with ticks", at - r, 64);
    extTick = 1'b0;

    // R11 narrow counter clamps code 15
    stopAll(); unlock();
    busWrite(A_CFG, cfgWord(15, 0, 1'b0, 1'b1, 1'b1, 1'b1)); s = cyc; at = -1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (irq16) begin at = cyc; break; end
    end
    chk("R11", "narrow irq delay code 15", at - s, 32768);
    chk("R4", "wide irq still low at 2^15", wdtIrq, 0);
    stopAll();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule